// File: doc/BRIEF.md
# Interrupt Bus Short-Message Receiver

This block listens to a two-wire interrupt message bus and rebuilds the short messages sent over it. Each message lasts 21 bus cycles with two bits per cycle. Field bits travel inverted on the wire, and an idle bus reads all-ones. The receiver restores the true bit values and decodes the message fields:

- destination mode
- three-bit delivery mode
- level and trigger bits
- eight-bit vector
- eight-bit destination

It also adds up the data cycles modulo 4 and compares the result with the checksum that was sent. In the first status cycle it can pull the bus low. It drives an error code when the checksum does not match. It drives a claim code when it is the focus receiver of a lowest-priority interrupt that is addressed to it.

A decoded message is reported by a one-cycle valid strobe with all fields beside it. The strobe only appears when three things hold: no node signalled an error, the checksum matched, and the destination selected this receiver. A destination selects this receiver by a physical ID compare or by the all-ones broadcast. A bus that stays quiet too long in the middle of a frame abandons the frame. The receiver then waits for the next start.

Top module: `irq_msg_rx`

## Requirements
- R1: A frame starts on the first bus sample that is not `11`; that sample is frame cycle 1, and the frame ends after cycle 21, after which the next non-`11` sample starts a new frame.
- R2: Each field bit is the inverse of its wire bit. The data cycles carry these pairs {bit1,bit0}:
  - cycle 6: {DM, M2}
  - cycle 7: {M1, M0}
  - cycle 8: {level, trigger}
  - cycles 9–12: vector bits 7..0
  - cycles 13–16: destination bits 7..0
  
  Each pair is listed most significant first.
- R3: The checksum is the sum modulo 4 of the de-inverted two-bit values of cycles 6–16. It is compared with the de-inverted value of cycle 17. On a mismatch the receiver drives `00` during cycle 19.
- R4: When the checksum matches, the delivery mode is lowest priority (`001`), `focus_en` is high and the destination selects this receiver, the receiver drives `01` during cycle 19.
- R5: The receiver drives the bus only during cycle 19 and only in the cases of R3 and R4. In every other cycle `drv_en` is low.
- R6: A destination selects this receiver only in physical mode (DM=0), when destination bits 3..0 equal `my_id` or equal `1111`. Logical mode (DM=1) never selects it.
- R7: `msg_valid` pulses for exactly one cycle, in the cycle after cycle 21 is sampled, with the decoded fields. It pulses only when the checksum matched, the bus did not read `00` in cycle 19 and the destination selected this receiver.
- R8: If the bus reads `00` in cycle 19, whichever node drove it, the message is discarded and no strobe follows.
- R9: If the bus reads `11` for ABORT_RUN consecutive samples at frame cycles up to 17, the frame is abandoned without a strobe or drive. The next non-`11` sample is then cycle 1 of a new frame.
- R10: After reset `msg_valid` and `drv_en` are low and the receiver waits for a frame start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_in | input | 2 | Resolved bus value sampled each cycle |
| my_id | input | 4 | Physical ID of this receiver |
| focus_en | input | 1 | This receiver is the focus for lowest-priority messages |
| drv_en | output | 1 | Receiver pulls the bus this cycle |
| drv_val | output | 2 | Value pulled onto the bus when drv_en is high |
| msg_valid | output | 1 | One-cycle strobe for an accepted message |
| msg_dm | output | 1 | Destination mode |
| msg_mode | output | 3 | Delivery mode |
| msg_level | output | 1 | Level bit |
| msg_trig | output | 1 | Trigger mode bit |
| msg_vector | output | 8 | Interrupt vector |
| msg_dest | output | 8 | Destination field |

## Verification
The bench builds the receiver with ABORT_RUN set to 6. With that setting, a quiet stretch in the middle of the data cycles abandons the frame well before the checksum cycle, and the abandon path and the clean restart after it can be reached in a short run. The bench frames keep every field run shorter than six idle pairs, so that legal messages are never cut.

// File: rtl/irq_msg_pkg.sv
// Shared constants and types for the interrupt bus short-message receiver.
// Assumes a fixed 21-cycle frame with two wire bits per cycle.
package irq_msg_pkg;
    localparam int POS_W      = 5;    // frame position counter width
    localparam int ID_W       = 4;    // physical destination ID width
    localparam int PAIR_W     = 2;    // bits per bus cycle
    localparam int DATA_FIRST = 6;    // first data cycle
    localparam int DATA_LAST  = 16;   // last data cycle
    localparam int DATA_CYC   = DATA_LAST - DATA_FIRST + 1;
    localparam int DATA_W     = DATA_CYC * PAIR_W;
    localparam int CKS_CYC    = 17;
    localparam int POST_CYC   = 18;
    localparam int STAT0_CYC  = 19;
    localparam int LAST_CYC   = 21;

    localparam logic [PAIR_W-1:0] BUS_IDLE  = 2'b11;
    localparam logic [PAIR_W-1:0] ST_ERROR  = 2'b00;
    localparam logic [PAIR_W-1:0] ST_CLAIM  = 2'b01;
    localparam logic [2:0]        MODE_LOWEST = 3'b001;

    typedef struct packed {
        logic       dm;
        logic [2:0] mode;
        logic       level;
        logic       trig;
        logic [7:0] vector;
        logic [7:0] dest;
    } irq_msg_t;
endpackage

// File: rtl/irq_frame_timer.sv
// Tracks the position inside a frame. A non-idle sample while waiting is
// cycle 1; the counter then holds the number of the next sample. Assumes
// the bus reads all-ones when nobody drives it. ABORT_RUN of 0 disables
// the abandon rule.
module irq_frame_timer
    import irq_msg_pkg::*;
#(
    parameter int ABORT_RUN = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PAIR_W-1:0] bus_in,
    output logic [POS_W-1:0]  pos,
    output logic              start,
    output logic              abort
);
    localparam int RUN_W = (ABORT_RUN > 0) ? $clog2(ABORT_RUN + 1) : 1;

    logic [POS_W-1:0] pos_q;
    logic [RUN_W-1:0] run_q;
    logic             bus_idle;

    assign bus_idle = (bus_in == BUS_IDLE);
    assign start    = (pos_q == '0) && !bus_idle;
    assign pos      = pos_q;

    generate
        if (ABORT_RUN > 0) begin : g_abort
            // Abandon when this idle sample completes the run, up to the checksum cycle
            assign abort = (pos_q != '0) && (pos_q <= POS_W'(CKS_CYC)) && bus_idle
                           && (run_q == RUN_W'(ABORT_RUN - 1));
        end else begin : g_no_abort
            assign abort = 1'b0;
        end
    endgenerate

    // Count consecutive idle samples inside a frame, saturating
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (pos_q == '0 || !bus_idle) begin
            run_q <= '0;
        end else if (run_q != {RUN_W{1'b1}}) begin
            run_q <= run_q + 1'b1;
        end
    end

    // Advance the frame position, or return to waiting at the end or on abandon
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q <= '0;
        end else if (pos_q == '0) begin
            pos_q <= bus_idle ? '0 : POS_W'(2);
        end else if (abort || pos_q == POS_W'(LAST_CYC)) begin
            pos_q <= '0;
        end else begin
            pos_q <= pos_q + 1'b1;
        end
    end
endmodule

// File: rtl/irq_field_capture.sv
// Shifts in the de-inverted data pairs of cycles 6..16, keeps a running
// modulo-4 sum of them and latches the de-inverted checksum of cycle 17.
// Assumes pos is the number of the sample at the current edge.
module irq_field_capture
    import irq_msg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [POS_W-1:0]  pos,
    input  logic [PAIR_W-1:0] bus_in,
    output logic [DATA_W-1:0] data_q,
    output logic [PAIR_W-1:0] sum_q,
    output logic [PAIR_W-1:0] cks_q
);
    logic              in_data;
    logic [PAIR_W-1:0] pair;

    assign pair    = ~bus_in;
    assign in_data = (pos >= POS_W'(DATA_FIRST)) && (pos <= POS_W'(DATA_LAST));

    // Collect data pairs and accumulate the checksum over them
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            sum_q  <= '0;
        end else if (start) begin
            sum_q  <= '0;
        end else if (in_data) begin
            data_q <= {data_q[DATA_W-PAIR_W-1:0], pair};
            sum_q  <= sum_q + pair;
        end
    end

    // Latch the transmitted checksum
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cks_q <= '0;
        end else if (pos == POS_W'(CKS_CYC)) begin
            cks_q <= pair;
        end
    end
endmodule

// File: rtl/irq_status_resp.sv
// Decides the status answer for cycle 19 and watches the bus in that cycle
// for an error code from any node. Assumes the sum and checksum are final
// by the postamble cycle.
module irq_status_resp
    import irq_msg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [POS_W-1:0]  pos,
    input  logic [PAIR_W-1:0] bus_in,
    input  logic [PAIR_W-1:0] sum_q,
    input  logic [PAIR_W-1:0] cks_q,
    input  logic              claim_req,
    output logic              drv_en,
    output logic [PAIR_W-1:0] drv_val,
    output logic              bad_q,
    output logic              err_q
);
    logic claim_q;

    // Judge the checksum and claim during the postamble; clear per frame
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bad_q   <= 1'b0;
            claim_q <= 1'b0;
        end else if (start) begin
            bad_q   <= 1'b0;
            claim_q <= 1'b0;
        end else if (pos == POS_W'(POST_CYC)) begin
            bad_q   <= (sum_q != cks_q);
            claim_q <= claim_req;
        end
    end

    // Record whether the bus carried an error code in cycle 19
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else if (start) begin
            err_q <= 1'b0;
        end else if (pos == POS_W'(STAT0_CYC)) begin
            err_q <= (bus_in == ST_ERROR);
        end
    end

    // Drive the status pair only while cycle 19 is on the bus
    always_comb begin
        drv_en  = (pos == POS_W'(STAT0_CYC)) && (bad_q || claim_q);
        drv_val = bad_q ? ST_ERROR : ST_CLAIM;
    end
endmodule

// File: rtl/irq_msg_rx.sv
// Top of the short-message receiver: frame timing, field capture, status
// answer, destination match and the accepted-message strobe. Assumes
// bus_in is the resolved wired-AND of all drivers, including drv_val.
module irq_msg_rx
    import irq_msg_pkg::*;
#(
    parameter int ABORT_RUN = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        bus_in,
    input  logic [3:0]        my_id,
    input  logic              focus_en,
    output logic              drv_en,
    output logic [1:0]        drv_val,
    output logic              msg_valid,
    output logic              msg_dm,
    output logic [2:0]        msg_mode,
    output logic              msg_level,
    output logic              msg_trig,
    output logic [7:0]        msg_vector,
    output logic [7:0]        msg_dest
);
    logic [POS_W-1:0]  pos;
    logic              start;
    logic              abort;
    logic [DATA_W-1:0] data_q;
    logic [PAIR_W-1:0] sum_q;
    logic [PAIR_W-1:0] cks_q;
    logic              bad_q;
    logic              err_q;
    logic              match;
    logic              claim_req;
    irq_msg_t          dec;
    irq_msg_t          out_q;
    logic              valid_q;

    irq_frame_timer #(.ABORT_RUN(ABORT_RUN)) u_timer (
        .clk(clk), .rst_n(rst_n), .bus_in(bus_in),
        .pos(pos), .start(start), .abort(abort)
    );

    irq_field_capture u_capture (
        .clk(clk), .rst_n(rst_n), .start(start), .pos(pos), .bus_in(bus_in),
        .data_q(data_q), .sum_q(sum_q), .cks_q(cks_q)
    );

    irq_status_resp u_status (
        .clk(clk), .rst_n(rst_n), .start(start), .pos(pos), .bus_in(bus_in),
        .sum_q(sum_q), .cks_q(cks_q), .claim_req(claim_req),
        .drv_en(drv_en), .drv_val(drv_val), .bad_q(bad_q), .err_q(err_q)
    );

    // Map the shifted data pairs onto message fields (first pair is oldest)
    assign dec = irq_msg_t'(data_q);

    // Physical ID compare or broadcast; logical mode never selects
    always_comb begin
        match     = !dec.dm && ((dec.dest[ID_W-1:0] == my_id)
                                || (dec.dest[ID_W-1:0] == {ID_W{1'b1}}));
        claim_req = match && focus_en && (dec.mode == MODE_LOWEST);
    end

    // Present accepted messages with a one-cycle strobe after cycle 21
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            out_q   <= '0;
        end else if (pos == POS_W'(LAST_CYC)) begin
            valid_q <= match && !bad_q && !err_q;
            out_q   <= dec;
        end else begin
            valid_q <= 1'b0;
        end
    end

    assign msg_valid  = valid_q;
    assign msg_dm     = out_q.dm;
    assign msg_mode   = out_q.mode;
    assign msg_level  = out_q.level;
    assign msg_trig   = out_q.trig;
    assign msg_vector = out_q.vector;
    assign msg_dest   = out_q.dest;
endmodule

// File: rtl/irq_msg_rx_chk.sv
// Property checker for irq_msg_rx, attached by bind. Observes ports and the
// frame position of the top.
module irq_msg_rx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] bus_in,
    input logic       drv_en,
    input logic [1:0] drv_val,
    input logic       msg_valid,
    input logic [4:0] pos
);
    a_r1_pos_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        pos <= 5'd21);
    a_r1_start_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (pos == 5'd0 && bus_in != 2'b11) |=> pos == 5'd2);
    a_r5_drive_only_status: assert property (@(posedge clk) disable iff (!rst_n)
        drv_en |-> pos == 5'd19);
    a_r3_status_code: assert property (@(posedge clk) disable iff (!rst_n)
        drv_en |-> (drv_val == 2'b00 || drv_val == 2'b01));
    a_r7_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |=> !msg_valid);
    a_r7_strobe_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> $past(pos) == 5'd21);
    a_r8_error_discards: assert property (@(posedge clk) disable iff (!rst_n)
        (pos == 5'd19 && bus_in == 2'b00) |-> ##3 !msg_valid);
endmodule

bind irq_msg_rx irq_msg_rx_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bus_in(bus_in), .drv_en(drv_en),
    .drv_val(drv_val), .msg_valid(msg_valid), .pos(pos)
);

// File: tb/irq_msg_rx_tb_top.sv
`timescale 1ns/1ps
module irq_msg_rx_tb_top;
    localparam int ABORT = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] tb_bus = 2'b11;
    logic [3:0] my_id = 4'h5;
    logic       focus_en = 1'b0;
    logic       drv_en;
    logic [1:0] drv_val;
    logic       msg_valid, msg_dm, msg_level, msg_trig;
    logic [2:0] msg_mode;
    logic [7:0] msg_vector, msg_dest;
    logic [1:0] bus;

    int checks = 0;
    int errors = 0;
    logic [21:0] exp_q[$];

    always #2.5 clk = ~clk;

    // Wired-AND of bench driver and receiver drive
    assign bus = tb_bus & (drv_en ? drv_val : 2'b11);

    irq_msg_rx #(.ABORT_RUN(ABORT)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_in(bus), .my_id(my_id), .focus_en(focus_en),
        .drv_en(drv_en), .drv_val(drv_val), .msg_valid(msg_valid), .msg_dm(msg_dm),
        .msg_mode(msg_mode), .msg_level(msg_level), .msg_trig(msg_trig),
        .msg_vector(msg_vector), .msg_dest(msg_dest)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Monitor: pop and compare each strobe against the scoreboard
    always @(negedge clk) begin
        if (rst_n && msg_valid) begin
            logic [21:0] got;
            got = {msg_dm, msg_mode, msg_level, msg_trig, msg_vector, msg_dest};
            if (exp_q.size() == 0) begin
                check(1'b0, "R7 unexpected strobe", {10'b0, got}, 32'h0);
            end else begin
                logic [21:0] e;
                e = exp_q.pop_front();
                check(got == e, "R2 decoded fields", {10'b0, got}, {10'b0, e});
            end
        end
    end

    // Driver: send one frame, check the cycle-19 answer, push the expected result
    task automatic send_frame(input logic dm, input logic [2:0] mode, input logic lvl,
                              input logic tm, input logic [7:0] vec, input logic [7:0] dest,
                              input bit corrupt, input bit other_err,
                              input bit exp_drv, input logic [1:0] exp_val,
                              input bit exp_valid, input string tag);
        logic [21:0] d;
        logic [1:0]  sum;
        logic [1:0]  w;
        d = {dm, mode, lvl, tm, vec, dest};
        sum = 2'b00;
        for (int i = 0; i < 11; i++) sum = sum + d[21-2*i -: 2];
        if (corrupt) sum = sum + 2'b01;
        if (exp_valid) exp_q.push_back(d);
        for (int k = 1; k <= 21; k++) begin
            @(negedge clk);
            if (k <= 5)        w = 2'b10;
            else if (k <= 16)  w = ~d[21-2*(k-6) -: 2];
            else if (k == 17)  w = ~sum;
            else if (k == 19)  w = other_err ? 2'b00 : 2'b11;
            else               w = 2'b11;
            tb_bus = w;
            #1;
            if (k == 19) begin
                check(drv_en == exp_drv, {tag, " drive enable in cycle 19"}, 32'(drv_en), 32'(exp_drv));
                if (exp_drv)
                    check(drv_val == exp_val, {tag, " status code"}, 32'(drv_val), 32'(exp_val));
            end else if (k == 18 || k == 20) begin
                check(!drv_en, "R5 no drive outside cycle 19", 32'(drv_en), 32'h0);
            end
        end
        @(negedge clk); tb_bus = 2'b11;
        @(negedge clk);
        #1;
        check(exp_q.size() == 0, {tag, " strobe outcome"}, 32'(exp_q.size()), 32'h0);
        exp_q.delete();
    endtask

    initial begin
        #(200000 * 5);
        check(1'b0, "watchdog expired", 32'h0, 32'h1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!msg_valid && !drv_en, "R10 reset state", {30'b0, msg_valid, drv_en}, 32'h0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(!msg_valid && !drv_en, "R10 idle after reset", {30'b0, msg_valid, drv_en}, 32'h0);

        // R1 R2 R6 R7: fixed mode to own ID
        send_frame(1'b0, 3'b000, 1'b1, 1'b0, 8'h4A, 8'h05, 0, 0, 0, 2'b00, 1, "R7 own ID");
        // R6: broadcast, upper destination bits carried through
        send_frame(1'b0, 3'b100, 1'b0, 1'b1, 8'hC3, 8'hAF, 0, 0, 0, 2'b00, 1, "R6 broadcast");
        // R6: other ID is not accepted
        send_frame(1'b0, 3'b000, 1'b1, 1'b1, 8'h5A, 8'h06, 0, 0, 0, 2'b00, 0, "R6 other ID");
        // R6: logical mode never selects
        send_frame(1'b1, 3'b000, 1'b1, 1'b0, 8'h66, 8'h05, 0, 0, 0, 2'b00, 0, "R6 logical mode");
        // R3: checksum mismatch drives 00 and drops the message
        send_frame(1'b0, 3'b000, 1'b1, 1'b0, 8'h99, 8'h05, 1, 0, 1, 2'b00, 0, "R3 bad checksum");
        // R4: focus claim for lowest priority
        focus_en = 1'b1;
        send_frame(1'b0, 3'b001, 1'b1, 1'b0, 8'hE7, 8'h35, 0, 0, 1, 2'b01, 1, "R4 focus claim");
        // R3 over R4: bad checksum wins even as focus
        send_frame(1'b0, 3'b001, 1'b0, 1'b1, 8'h7E, 8'h15, 1, 0, 1, 2'b00, 0, "R3 bad checksum as focus");
        // R5: focus for a message to another ID does not drive
        send_frame(1'b0, 3'b001, 1'b1, 1'b0, 8'hB4, 8'h16, 0, 0, 0, 2'b00, 0, "R5 focus other ID");
        focus_en = 1'b0;
        // R5: lowest priority without focus: no drive, still accepted
        send_frame(1'b0, 3'b001, 1'b1, 1'b1, 8'h3C, 8'h25, 0, 0, 0, 2'b00, 1, "R5 no focus");
        // R8: another node signals error
        send_frame(1'b0, 3'b000, 1'b1, 1'b0, 8'hD2, 8'h05, 0, 1, 0, 2'b00, 0, "R8 remote error");

        // R9: frame goes quiet after arbitration, then a clean frame follows
        for (int k = 1; k <= 5; k++) begin
            @(negedge clk); tb_bus = 2'b10;
        end
        for (int k = 0; k < ABORT + 2; k++) begin
            @(negedge clk); tb_bus = 2'b11;
            #1;
            check(!drv_en && !msg_valid, "R9 abandoned frame quiet",
                  {30'b0, drv_en, msg_valid}, 32'h0);
        end
        send_frame(1'b0, 3'b010, 1'b1, 1'b0, 8'h81, 8'h05, 0, 0, 0, 2'b00, 1, "R9 frame after abandon");
        // R1: back-to-back frame after the minimal gap
        send_frame(1'b0, 3'b000, 1'b0, 1'b1, 8'h2D, 8'hF5, 0, 0, 0, 2'b00, 1, "R1 back to back");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule